// File: doc/BRIEF.md
# Video Output Nibble Crossbar

This block sits between an internal 36-bit video data bus and the 36 pins of a video output port. The pins form nine groups of four. Each group has its own 8-bit control register, and that register decides what the group does. It picks which 4-bit slice of the internal bus reaches the group. It can mirror the order of the four bits. It turns the group's drivers on or off. For a group that is off, it chooses whether the pins float or are pulled to a driven zero. Narrow video formats sit at the top of the internal bus, so an 8-bit stream occupies the high nibbles. Software routes those nibbles down to whichever pins the attached receiver uses.

Registers are loaded through a single write port that takes an address, a data byte and a strobe. A combinational read port returns the stored byte for any group address. The path from the internal bus to the pins contains no registers. Only the configuration is clocked.

Top module: `vxbar_top`

## Requirements
- R1: After reset every control register holds 0x00. Every `pin_out` bit is 0 and every `pin_oe` bit is 1, so all groups are disabled and driven low.
- R2: A write with `cfg_we`=1 at address n (0..8) stores `cfg_wdata` in register n from the next rising clock edge. The outputs do not change before that edge. Register n governs pins [4n+3:4n]. Without a strobe, no register changes.
- R3: Writes to addresses 9..15 change no register. Reads at addresses 9..15 return 0x00.
- R4: When bit 7 (enable) of register n is 1 and bits 3:0 hold k in 0..8, pins [4n+3:4n] carry `vid_in`[4k+3:4k] and the group's four `pin_oe` bits are 1.
- R5: When a group is enabled and its select field is 9..15, its pins carry 0000.
- R6: When bit 4 (mirror) is 1, the routed nibble is bit-reversed: pin 4n+i carries nibble bit 3-i.
- R7: When bit 7 is 0 and bit 6 is 1, the group's four `pin_oe` bits are 0 (high impedance) and its pins carry 0.
- R8: When bit 7 is 0 and bit 6 is 0, the group's four `pin_oe` bits are 1 and its pins carry 0 (driven low).
- R9: Bit 5 is stored and read back as written. It has no effect on `pin_out` or `pin_oe`.
- R10: A change on `vid_in` appears on the enabled pins in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Write address, group index |
| cfg_wdata | input | 8 | Write data byte |
| cfg_raddr | input | 4 | Read address |
| cfg_rdata | output | 8 | Stored byte at `cfg_raddr`, 0 when out of range |
| vid_in | input | 36 | Internal video data bus |
| pin_out | output | 36 | Pin data values |
| pin_oe | output | 36 | Per-pin driver enable, 1 = driven |

## Verification
On every cycle, the bound checker confirms three things. The enable and idle-level bits of each group map onto its driver-enable nibble. Disabled and out-of-range groups carry zeros. Register writes land on the next edge, and writes above address 8 or without a strobe leave the configuration untouched. The checker cannot see which source nibble reaches which pins, the bit mirroring, the combinational response to `vid_in`, or the fact that the spare bit has no effect. Only the bench scenarios show these, by comparing the pins against an independent model across several data patterns.

// File: rtl/vxbar_pkg.sv
package vxbar_pkg;

    localparam int NIB_W  = 4;
    localparam int CTRL_W = 8;
    localparam int SEL_W  = 4;

    typedef struct packed {
        logic             en;
        logic             hiz;
        logic             spare;
        logic             rev;
        logic [SEL_W-1:0] sel;
    } grp_ctrl_t;

    function automatic logic [NIB_W-1:0] nib_mirror(input logic [NIB_W-1:0] n);
        logic [NIB_W-1:0] r;
        for (int i = 0; i < NIB_W; i++) begin
            r[i] = n[NIB_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/vxbar_regfile.sv
module vxbar_regfile
    import vxbar_pkg::*;
#(
    parameter int GROUPS = 9,
    parameter int ADDR_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [CTRL_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [CTRL_W-1:0]           rd_data,
    output grp_ctrl_t [GROUPS-1:0]      ctrl_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(GROUPS - 1);

    typedef struct packed {
        grp_ctrl_t [GROUPS-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (wr_addr <= LAST_ADDR)) begin
            for (int g = 0; g < GROUPS; g++) begin
                if (wr_addr == ADDR_W'(g)) begin
                    st_d.regs[g] = grp_ctrl_t'(wr_data);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (rd_addr == ADDR_W'(g)) begin
                rd_data = st_q.regs[g];
            end
        end
    end

    assign ctrl_o = st_q.regs;

endmodule

// File: rtl/vxbar_lane.sv
module vxbar_lane
    import vxbar_pkg::*;
#(
    parameter int GROUPS = 9
) (
    input  logic [GROUPS*NIB_W-1:0] vid_bus,
    input  grp_ctrl_t               ctrl,
    output logic [NIB_W-1:0]        pins,
    output logic [NIB_W-1:0]        oe
);

    logic [NIB_W-1:0] picked;
    logic [NIB_W-1:0] routed;

    always_comb begin
        picked = '0;
        for (int k = 0; k < GROUPS; k++) begin
            if (ctrl.sel == SEL_W'(k)) begin
                picked = vid_bus[k*NIB_W +: NIB_W];
            end
        end
    end

    always_comb begin
        routed = ctrl.rev ? nib_mirror(picked) : picked;
        pins   = ctrl.en ? routed : '0;
        oe     = (ctrl.en || !ctrl.hiz) ? '1 : '0;
    end

endmodule

// File: rtl/vxbar_top.sv
module vxbar_top
    import vxbar_pkg::*;
#(
    parameter int GROUPS = 9,
    localparam int BUS_W  = GROUPS * NIB_W,
    localparam int ADDR_W = (GROUPS > 8) ? $clog2(GROUPS) : 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] cfg_raddr,
    output logic [CTRL_W-1:0] cfg_rdata,
    input  logic [BUS_W-1:0]  vid_in,
    output logic [BUS_W-1:0]  pin_out,
    output logic [BUS_W-1:0]  pin_oe
);

    grp_ctrl_t [GROUPS-1:0]    ctrl;
    logic [GROUPS*CTRL_W-1:0]  ctrl_flat;

    vxbar_regfile #(
        .GROUPS (GROUPS),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .rd_addr (cfg_raddr),
        .rd_data (cfg_rdata),
        .ctrl_o  (ctrl)
    );

    assign ctrl_flat = ctrl;

    for (genvar g = 0; g < GROUPS; g++) begin : g_lane
        vxbar_lane #(
            .GROUPS (GROUPS)
        ) u_lane (
            .vid_bus (vid_in),
            .ctrl    (ctrl[g]),
            .pins    (pin_out[g*NIB_W +: NIB_W]),
            .oe      (pin_oe[g*NIB_W +: NIB_W])
        );
    end

endmodule

// File: rtl/vxbar_chk.sv
module vxbar_chk #(
    parameter int GROUPS = 9,
    parameter int ADDR_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_we,
    input logic [ADDR_W-1:0]     cfg_addr,
    input logic [7:0]            cfg_wdata,
    input logic [GROUPS*4-1:0]   pin_out,
    input logic [GROUPS*4-1:0]   pin_oe,
    input logic [GROUPS*8-1:0]   ctrl_flat
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(GROUPS - 1);

    function automatic logic [7:0] slot(input logic [GROUPS*8-1:0] v,
                                        input logic [ADDR_W-1:0] a);
        logic [GROUPS*8-1:0] s;
        s = v >> (32'(a) * 8);
        return s[7:0];
    endfunction

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr <= TOP_ADDR) |=> (slot(ctrl_flat, $past(cfg_addr)) == $past(cfg_wdata))); // R2

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(ctrl_flat)); // R2

    AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr > TOP_ADDR) |=> $stable(ctrl_flat)); // R3

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        AST_ON_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_flat[g*8+7] |-> (pin_oe[g*4 +: 4] == 4'hF)); // R4

        AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_flat[g*8+7] && ctrl_flat[g*8 +: 4] > 4'(GROUPS - 1)) |-> (pin_out[g*4 +: 4] == 4'h0)); // R5

        AST_OFF_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_flat[g*8+7] && ctrl_flat[g*8+6]) |-> (pin_oe[g*4 +: 4] == 4'h0)); // R7

        AST_FLOAT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_oe[g*4 +: 4] == 4'h0) |-> (pin_out[g*4 +: 4] == 4'h0)); // R7

        AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_flat[g*8+7] && !ctrl_flat[g*8+6]) |-> (pin_oe[g*4 +: 4] == 4'hF && pin_out[g*4 +: 4] == 4'h0)); // R8
    end

endmodule

bind vxbar_top vxbar_chk #(
    .GROUPS (GROUPS),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .ctrl_flat (ctrl_flat)
);

// File: tb/vxbar_top_bench.sv
`timescale 1ns/1ps
module vxbar_top_bench;

    localparam int G = 9;
    localparam int W = 36;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_addr = '0;
    logic [7:0]   cfg_wdata = '0;
    logic [3:0]   cfg_raddr = '0;
    logic [7:0]   cfg_rdata;
    logic [W-1:0] vid_in = '0;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [W-1:0] o;
        logic [W-1:0] oe;
        logic [7:0]   rd;
        string        tag;
    } item_t;

    item_t sb_q[$];
    logic [7:0] m_reg [G];

    always #2.5 clk = ~clk;

    vxbar_top u_vxbar_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_raddr (cfg_raddr),
        .cfg_rdata (cfg_rdata),
        .vid_in    (vid_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // expected pins from the requirement text (R4..R9)
    task automatic expect_now(input string tag);
        item_t it;
        it.o = '0;
        it.oe = '0;
        for (int g = 0; g < G; g++) begin
            logic [7:0] c;
            logic [3:0] nib;
            c = m_reg[g];
            nib = (c[3:0] < 9) ? vid_in[c[3:0]*4 +: 4] : 4'h0;
            if (c[4]) nib = {nib[0], nib[1], nib[2], nib[3]};
            it.o[g*4 +: 4]  = c[7] ? nib : 4'h0;
            it.oe[g*4 +: 4] = (c[7] || !c[6]) ? 4'hF : 4'h0;
        end
        it.rd = (cfg_raddr < 9) ? m_reg[cfg_raddr] : 8'h00;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic settle_check(input string tag);
        #1;
        expect_now(tag);
        wait (sb_q.size() == 0);
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = d;
        @(posedge clk);
        if (a < 9) m_reg[a] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        for (int g = 0; g < G; g++) m_reg[g] = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            n_checks++;
            if (pin_out !== it.o) begin
                n_errors++;
                $display("FAIL %s pin_out actual=%h expected=%h", it.tag, pin_out, it.o);
            end else if (pin_oe !== it.oe) begin
                n_errors++;
                $display("FAIL %s pin_oe actual=%h expected=%h", it.tag, pin_oe, it.oe);
            end else if (cfg_rdata !== it.rd) begin
                n_errors++;
                $display("FAIL %s rdata actual=%h expected=%h", it.tag, cfg_rdata, it.rd);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        vid_in = 36'h876543210;
        // R1: reset state of every register and pin
        for (int a = 0; a < G; a++) begin
            cfg_raddr = 4'(a);
            settle_check("R1 reset");
        end

        // R2: the write is not visible before the edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 8'h88; cfg_raddr = 4'd0;
        settle_check("R2 before edge");
        @(posedge clk);
        m_reg[0] = 8'h88;
        @(negedge clk);
        cfg_we = 1'b0;
        settle_check("R2 after edge");

        // R4: route each group from a distinct source nibble
        for (int g = 0; g < G; g++) begin
            write_reg(4'(g), 8'h80 | 8'(8 - g));
            cfg_raddr = 4'(g);
            settle_check("R4 route");
        end

        // R10: data path reacts without a clock edge
        @(posedge clk);
        #1;
        vid_in = 36'h1C3A5E7B9;
        settle_check("R10 comb path");
        vid_in = 36'hF0E1D2C3B;
        settle_check("R10 comb path 2");

        // R6: mirrored nibble
        write_reg(4'd3, 8'h92);
        cfg_raddr = 4'd3;
        settle_check("R6 mirror");
        write_reg(4'd1, 8'h97);
        settle_check("R6 mirror 2");

        // R5: out of range select
        write_reg(4'd4, 8'h8C);
        cfg_raddr = 4'd4;
        settle_check("R5 sel 12");
        write_reg(4'd5, 8'h99);
        settle_check("R5 sel 9 mirrored");

        // R7: disabled, floating
        write_reg(4'd6, 8'h43);
        cfg_raddr = 4'd6;
        settle_check("R7 float");

        // R8: disabled, driven low
        write_reg(4'd7, 8'h05);
        cfg_raddr = 4'd7;
        settle_check("R8 low");

        // R9: spare bit stored, no effect on routing
        write_reg(4'd2, 8'hA5);
        cfg_raddr = 4'd2;
        settle_check("R9 spare set");
        write_reg(4'd2, 8'h85);
        settle_check("R9 spare clear");
        write_reg(4'd8, 8'h60);
        cfg_raddr = 4'd8;
        settle_check("R9 spare on float");

        // R3: high addresses ignored, read as zero
        write_reg(4'd9, 8'hFF);
        write_reg(4'd15, 8'h81);
        write_reg(4'd12, 8'h40);
        cfg_raddr = 4'd12;
        settle_check("R3 high addr read");
        for (int a = 0; a < G; a++) begin
            cfg_raddr = 4'(a);
            settle_check("R3 regs kept");
        end

        // R1: reset again from a busy configuration
        do_reset();
        cfg_raddr = 4'd2;
        settle_check("R1 re-reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule